// File: doc/BRIEF.md
# Soft-Reset Diagnostic Sequencer

This block is the device-side controller for a legacy soft reset that the host spreads over two register frames. The first qualifying frame carries the reset bit set. It makes the device drop back to its default register contents and start its internal diagnostics. The second qualifying frame carries the reset bit cleared. It lets the sequencer go on to wait for the diagnostics to end. Once the diagnostics have finished, the error and status registers are loaded with the outcome, and one device-to-host register frame is requested to report it. The request is held until the transmit side acknowledges it.

The frames arrive already decoded: a valid strobe, the frame type, the control (C) bit and the reset bit. Frame parsing, the link layer and link-level reset all sit outside this block. Nothing here drives link state, so a soft reset only touches device-side logic.

Top module: `srst_diag_seq`

## Requirements
- R1: During and straight after synchronous reset, `busy`, `tx_req`, `reinit_pulse` and `diag_start` are 0, and `err_reg` and `stat_reg` read 00h.
- R2: A qualifying frame is one where `rx_valid`=1, `rx_type`=27h and `rx_c`=0. A qualifying frame with `rx_srst`=1 received while idle makes `reinit_pulse` and `diag_start` high for exactly one cycle, in the cycle after the frame. In that same cycle `busy` rises, `err_reg` becomes 00h and `stat_reg` becomes 80h.
- R3: While the reset is asserted, the following are ignored: frames with `rx_c`=1, frames of another type, and repeated qualifying frames with `rx_srst`=1. None of them gives a new pulse or moves toward the report.
- R4: A qualifying frame with `rx_srst`=0 releases the reset. No report is requested until `diag_done` has been seen after the reset was entered.
- R5: If diagnostics finished while the reset was still asserted, `tx_req` rises two cycles after the release frame.
- R6: A passing result (`diag_pass`=1) loads `err_reg`=01h and `stat_reg`=50h. The registers are updated in the same cycle that `tx_req` rises.
- R7: A failing result loads `err_reg`=02h (never 01h) and `stat_reg`=51h.
- R8: `tx_req` stays high until `tx_ack` is sampled high. In the next cycle `tx_req` and `busy` are 0.
- R9: Frames received while diagnostics are running or the report is pending are ignored, and so is a release frame received while idle.
- R10: A `diag_done` seen before the reset is entered does not count as completion of the diagnostics that the reset starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Decoded frame present this cycle |
| rx_type | input | 8 | Frame type code |
| rx_c | input | 1 | Command/control bit of the frame |
| rx_srst | input | 1 | Soft-reset bit of the frame |
| diag_done | input | 1 | Diagnostics finished (pulse or level) |
| diag_pass | input | 1 | Diagnostics result, valid with diag_done |
| tx_ack | input | 1 | Report frame accepted by transmit side |
| reinit_pulse | output | 1 | One-cycle request to restore defaults |
| diag_start | output | 1 | One-cycle diagnostics start |
| err_reg | output | 8 | Error register value |
| stat_reg | output | 8 | Status register value |
| tx_req | output | 1 | Request to send device-to-host register frame |
| busy | output | 1 | Soft-reset sequence in progress |

## Verification
The assertions check several rules on every cycle. The report request holds until it is acknowledged. A re-initialize pulse lasts one cycle and only follows a qualifying assert frame. The error and status values agree with each other while a report is pending. `tx_req` is never high without `busy`. Other behaviour only shows up across a whole scenario, and a reference model in the bench compares every output each cycle to cover it. This covers ignoring control-bit, wrong-type and repeated frames, the two-cycle latency when diagnostics finished early, discarding a completion that came before the reset, and the exact failure code.

// File: rtl/srst_pkg.sv
// Package: shared state encoding for the soft-reset diagnostic sequencer.
// Assumes: imported by every module of the sequencer.
package srst_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_RESET  = 2'd1,
        SQ_DIAG   = 2'd2,
        SQ_REPORT = 2'd3
    } sq_state_t;
endpackage

// File: rtl/srst_frame_qual.sv
// srst_frame_qual: turns decoded frame fields into reset-assert and
// reset-release events.
// Assumes: fields are valid only while rx_valid is high; purely combinational.
module srst_frame_qual #(
    parameter int                TYPE_W   = 8,
    parameter logic [TYPE_W-1:0] REG_TYPE = 8'h27
) (
    input  logic              rx_valid,
    input  logic [TYPE_W-1:0] rx_type,
    input  logic              rx_c,
    input  logic              rx_srst,
    output logic              assert_ev,
    output logic              release_ev
);
    logic hit;

    // Qualify: register frame with control bit clear, then split on reset bit.
    always_comb begin
        hit        = rx_valid && (rx_type == REG_TYPE) && !rx_c;
        assert_ev  = hit && rx_srst;
        release_ev = hit && !rx_srst;
    end
endmodule

// File: rtl/srst_diag_latch.sv
// srst_diag_latch: remembers a diagnostics completion and its result.
// Assumes: clr is high in the cycle the reset is entered; a completion seen
// before that point is discarded.
module srst_diag_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic diag_done,
    input  logic diag_pass,
    output logic done_eff,
    output logic pass_eff
);
    logic done_q;
    logic pass_q;

    // Capture completion; a fresh reset entry clears it.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            done_q <= 1'b0;
            pass_q <= 1'b0;
        end else if (diag_done) begin
            done_q <= 1'b1;
            pass_q <= diag_pass;
        end
    end

    // Present completion either from this cycle's input or from the latch.
    always_comb begin
        done_eff = diag_done || done_q;
        pass_eff = diag_done ? diag_pass : pass_q;
    end
endmodule

// File: rtl/srst_seq_fsm.sv
// srst_seq_fsm: idle -> reset asserted -> diagnostics -> report -> idle.
// Assumes: events come from srst_frame_qual; done_eff from srst_diag_latch.
// It drives no link-level signal, so the link is never disturbed.
module srst_seq_fsm
    import srst_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic assert_ev,
    input  logic release_ev,
    input  logic done_eff,
    input  logic tx_ack,
    output logic enter_rst,
    output logic upd,
    output logic reinit_pulse,
    output logic tx_req,
    output logic busy
);
    sq_state_t state_q;
    sq_state_t state_d;

    // Decode transitions and the one-cycle register-update strobe.
    always_comb begin
        state_d   = state_q;
        enter_rst = 1'b0;
        upd       = 1'b0;
        unique case (state_q)
            SQ_IDLE: begin
                if (assert_ev) begin
                    state_d   = SQ_RESET;
                    enter_rst = 1'b1;
                end
            end
            SQ_RESET: begin
                if (release_ev) state_d = SQ_DIAG;
            end
            SQ_DIAG: begin
                if (done_eff) begin
                    state_d = SQ_REPORT;
                    upd     = 1'b1;
                end
            end
            SQ_REPORT: begin
                if (tx_ack) state_d = SQ_IDLE;
            end
            default: state_d = SQ_IDLE;
        endcase
    end

    // State register and registered re-initialize pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= SQ_IDLE;
            reinit_pulse <= 1'b0;
        end else begin
            state_q      <= state_d;
            reinit_pulse <= enter_rst;
        end
    end

    // Outputs derived from the current state.
    always_comb begin
        tx_req = (state_q == SQ_REPORT);
        busy   = (state_q != SQ_IDLE);
    end

    // R8: the report request persists until acknowledged.
    a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req && !tx_ack |=> tx_req);
    // R2: re-initialize is a single-cycle pulse.
    a_r2_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        reinit_pulse |=> !reinit_pulse);
    // R2: a pulse only follows a qualifying assert frame.
    a_r2_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
        reinit_pulse |-> $past(assert_ev));
    // R8: acknowledge of a pending request returns to idle.
    a_r8_ack_idle: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req && tx_ack |=> !busy);
endmodule

// File: rtl/srst_result_regs.sv
// srst_result_regs: error and status register values seen by the host.
// Assumes: clr on reset entry, upd once when diagnostics complete.
module srst_result_regs #(
    parameter int               REG_W     = 8,
    parameter logic [REG_W-1:0] ERR_OK    = 8'h01,
    parameter logic [REG_W-1:0] ERR_FAIL  = 8'h02,
    parameter logic [REG_W-1:0] STAT_BUSY = 8'h80,
    parameter logic [REG_W-1:0] STAT_OK   = 8'h50,
    parameter logic [REG_W-1:0] STAT_FAIL = 8'h51
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             upd,
    input  logic             pass,
    output logic [REG_W-1:0] err_reg,
    output logic [REG_W-1:0] stat_reg
);
    // Load defaults on reset entry, the diagnostic outcome on update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_reg  <= '0;
            stat_reg <= '0;
        end else if (clr) begin
            err_reg  <= '0;
            stat_reg <= STAT_BUSY;
        end else if (upd) begin
            err_reg  <= pass ? ERR_OK  : ERR_FAIL;
            stat_reg <= pass ? STAT_OK : STAT_FAIL;
        end
    end

    // R7: a failure code never reads as the success code.
    a_r7_fail_code: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_reg == STAT_FAIL) |-> (err_reg != ERR_OK));
endmodule

// File: rtl/srst_diag_seq.sv
// srst_diag_seq: top of the device soft-reset diagnostic sequencer.
// Assumes: decoded frame fields and diagnostics handshake from neighbours;
// report frame content is built elsewhere from err_reg and stat_reg.
module srst_diag_seq #(
    parameter int                TYPE_W    = 8,
    parameter int                REG_W     = 8,
    parameter logic [TYPE_W-1:0] REG_TYPE  = 8'h27,
    parameter logic [REG_W-1:0]  ERR_OK    = 8'h01,
    parameter logic [REG_W-1:0]  ERR_FAIL  = 8'h02,
    parameter logic [REG_W-1:0]  STAT_BUSY = 8'h80,
    parameter logic [REG_W-1:0]  STAT_OK   = 8'h50,
    parameter logic [REG_W-1:0]  STAT_FAIL = 8'h51
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [TYPE_W-1:0] rx_type,
    input  logic              rx_c,
    input  logic              rx_srst,
    input  logic              diag_done,
    input  logic              diag_pass,
    input  logic              tx_ack,
    output logic              reinit_pulse,
    output logic              diag_start,
    output logic [REG_W-1:0]  err_reg,
    output logic [REG_W-1:0]  stat_reg,
    output logic              tx_req,
    output logic              busy
);
    logic assert_ev, release_ev, enter_rst, upd, done_eff, pass_eff;

    srst_frame_qual #(.TYPE_W(TYPE_W), .REG_TYPE(REG_TYPE)) u_qual (
        .rx_valid(rx_valid), .rx_type(rx_type), .rx_c(rx_c),
        .rx_srst(rx_srst), .assert_ev(assert_ev), .release_ev(release_ev));

    srst_diag_latch u_latch (
        .clk(clk), .rst_n(rst_n), .clr(enter_rst), .diag_done(diag_done),
        .diag_pass(diag_pass), .done_eff(done_eff), .pass_eff(pass_eff));

    srst_seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .assert_ev(assert_ev),
        .release_ev(release_ev), .done_eff(done_eff), .tx_ack(tx_ack),
        .enter_rst(enter_rst), .upd(upd), .reinit_pulse(reinit_pulse),
        .tx_req(tx_req), .busy(busy));

    srst_result_regs #(
        .REG_W(REG_W), .ERR_OK(ERR_OK), .ERR_FAIL(ERR_FAIL),
        .STAT_BUSY(STAT_BUSY), .STAT_OK(STAT_OK), .STAT_FAIL(STAT_FAIL)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .clr(enter_rst), .upd(upd),
        .pass(pass_eff), .err_reg(err_reg), .stat_reg(stat_reg));

    // Diagnostics start coincides with the re-initialize pulse.
    always_comb diag_start = reinit_pulse;

    // R6: a pending report carries a consistent error/status pair.
    a_r6_pair: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |-> ((err_reg == ERR_OK) == (stat_reg == STAT_OK)));
    // R8: a request is only raised while the sequence is busy.
    a_r8_busy_req: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |-> busy);
endmodule

// File: tb/tb_srst_diag_seq.sv
module tb_srst_diag_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0, rx_c = 1'b0, rx_srst = 1'b0;
    logic [7:0] rx_type = 8'h00;
    logic       diag_done = 1'b0, diag_pass = 1'b0, tx_ack = 1'b0;
    logic       reinit_pulse, diag_start, tx_req, busy;
    logic [7:0] err_reg, stat_reg;

    int n_tests = 0;
    int n_fail  = 0;
    bit done_flag = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    srst_diag_seq dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_type(rx_type),
        .rx_c(rx_c), .rx_srst(rx_srst), .diag_done(diag_done),
        .diag_pass(diag_pass), .tx_ack(tx_ack), .reinit_pulse(reinit_pulse),
        .diag_start(diag_start), .err_reg(err_reg), .stat_reg(stat_reg),
        .tx_req(tx_req), .busy(busy));

    // Behavioural reference model: phase 0 idle, 1 held, 2 diag, 3 report.
    int       m_ph = 0;
    bit       m_pulse = 0, m_seen = 0, m_res = 0;
    int       m_err = 0, m_stat = 0;
    always @(posedge clk) begin
        bit good;
        bit fin;
        bit res;
        good = rx_valid && rx_type == 8'h27 && !rx_c;
        m_pulse = 0;
        if (!rst_n) begin
            m_ph = 0; m_seen = 0; m_res = 0; m_err = 0; m_stat = 0;
        end else if (m_ph == 0) begin
            if (good && rx_srst) begin
                m_ph = 1; m_pulse = 1; m_err = 0; m_stat = 'h80; m_seen = 0;
            end
        end else if (m_ph == 1) begin
            if (diag_done) begin m_seen = 1; m_res = diag_pass; end
            if (good && !rx_srst) m_ph = 2;
        end else if (m_ph == 2) begin
            fin = m_seen || diag_done;
            res = diag_done ? diag_pass : m_res;
            if (fin) begin
                m_ph = 3;
                m_err  = res ? 'h01 : 'h02;
                m_stat = res ? 'h50 : 'h51;
            end
        end else begin
            if (tx_ack) m_ph = 0;
        end
    end

    task automatic chk(input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (!done_flag) begin
            chk("R2", "reinit_pulse", reinit_pulse, m_pulse);
            chk("R2", "diag_start", diag_start, m_pulse);
            chk("R6", "err_reg", err_reg, m_err);
            chk("R7", "stat_reg", stat_reg, m_stat);
            chk("R8", "tx_req", tx_req, m_ph == 3);
            chk("R8", "busy", busy, m_ph != 0);
        end
    end

    task automatic frame(input logic [7:0] t, input logic c, input logic s);
        rx_valid = 1; rx_type = t; rx_c = c; rx_srst = s;
        @(negedge clk);
        rx_valid = 0; rx_type = 8'h00; rx_c = 0; rx_srst = 0;
    endtask

    task automatic done_pulse(input logic p);
        diag_done = 1; diag_pass = p;
        @(negedge clk);
        diag_done = 0; diag_pass = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run;
        done_flag = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        idle(3);
        chk("R1", "busy in reset", busy, 0);
        chk("R1", "stat in reset", stat_reg, 0);
        rst_n = 1;
        idle(1);
        chk("R1", "tx_req after reset", tx_req, 0);
        chk("R1", "err after reset", err_reg, 0);

        // R10: a completion before entry is discarded.
        done_pulse(1);
        // R9: a release frame while idle is ignored.
        frame(8'h27, 0, 0);
        chk("R9", "busy after idle release", busy, 0);

        // R2: assert frame.
        frame(8'h27, 0, 1);
        chk("R2", "reinit pulse", reinit_pulse, 1);
        chk("R2", "stat busy code", stat_reg, 'h80);
        idle(1);
        chk("R2", "pulse single", reinit_pulse, 0);

        // R3: diag finishes early, then frames that must be ignored.
        done_pulse(1);
        frame(8'h27, 1, 0);
        frame(8'h34, 0, 0);
        frame(8'h27, 0, 1);
        idle(2);
        chk("R3", "no report from ignored frames", tx_req, 0);
        chk("R3", "no repeat pulse", reinit_pulse, 0);
        chk("R3", "still busy", busy, 1);

        // R5: release with diagnostics already finished.
        frame(8'h27, 0, 0);
        chk("R5", "tx_req one cycle after release", tx_req, 0);
        idle(1);
        chk("R5", "tx_req two cycles after release", tx_req, 1);
        chk("R6", "pass err", err_reg, 'h01);
        chk("R6", "pass stat", stat_reg, 'h50);
        idle(4);
        chk("R8", "request held", tx_req, 1);
        tx_ack = 1; @(negedge clk); tx_ack = 0;
        chk("R8", "idle after ack", busy, 0);

        // R4 / R7 / R9 / R10: stale done before entry, failure during diag.
        done_pulse(1);
        frame(8'h27, 0, 1);
        idle(2);
        frame(8'h27, 0, 0);
        frame(8'h27, 0, 1);
        idle(5);
        chk("R4", "waits for diagnostics", tx_req, 0);
        chk("R10", "stale completion ignored", busy, 1);
        chk("R9", "no new pulse in diag", reinit_pulse, 0);
        done_pulse(0);
        chk("R7", "fail err", err_reg, 'h02);
        chk("R7", "fail stat", stat_reg, 'h51);
        frame(8'h27, 0, 1);
        chk("R9", "frame in report ignored", stat_reg, 'h51);
        tx_ack = 1; @(negedge clk); tx_ack = 0;
        chk("R8", "idle after fail ack", tx_req, 0);
        idle(3);
        finish_run();
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            finish_run();
        end
    end
endmodule